// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running nanosecond time of day for precision time protocol support. When a reference tick arrives and counting is enabled, it adds a fixed 8 ns step to a 40-bit nanosecond count. The rate is trimmed by a signed fractional term that goes into a 32-bit sub-nanosecond accumulator on every tick. When that accumulator carries out, the count gains one nanosecond on that tick. When it borrows, the count loses one.

Software sees five 32-bit registers on a simple read/write port. A read of the sub-nanosecond word captures the whole count in one cycle, so the low and high words read afterwards belong together. To set the time, software stages the low word and then writes the high word, which loads both halves at once. A control bit stops the counter. It is set at reset, so counting starts only after software clears it.

Top module: `ptp_tod_counter`

## Requirements
- R1: Each clock edge with `tick` high and counting enabled adds 8 ns to the count, plus or minus a one-nanosecond trim correction. An edge with `tick` low leaves the count unchanged.
- R2: The trim register is at address 3. Bits 30:0 are a magnitude and bit 31 is the sign. With bit 31 clear, each counted tick adds the magnitude to the 32-bit accumulator modulo 2^32, and a carry out adds one more nanosecond on that tick.
- R3: With bit 31 of the trim register set, each counted tick subtracts the magnitude from the accumulator modulo 2^32, and a borrow removes one nanosecond on that tick.
- R4: The low word at address 1 is count bits 31:0. The high word at address 2 holds count bits 39:32 in its bits 7:0, and its bits 31:8 always read zero. The count wraps modulo 2^40.
- R5: A read of address 0 returns the accumulator and captures the whole count. Reads of the low and high words that follow return the captured value, even if the counter has advanced since the capture.
- R6: A capture stays held until the high word is read. While no capture is held, a read of the low word returns the live value and takes a capture.
- R7: A write to address 1 only stages a value. A write to address 2 loads count bits 39:32 from wdata bits 7:0 and count bits 31:0 from the staged value, and clears the accumulator.
- R8: A write to address 0 loads the accumulator directly. The next tick's carry or borrow uses the loaded value.
- R9: Bit 31 of the control register at address 4 halts counting while set. It is set at reset and reads back in place.
- R10: After reset the count, the accumulator and the trim register are zero, and `rdata` is zero.
- R11: `rdata` takes the addressed value on the clock edge after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference tick, one clock-enable pulse per 8 ns period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address (0 sub-ns, 1 low, 2 high, 3 trim, 4 control) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
A fault in the accumulator does not show at once. It appears only as a nanosecond count that is off by one after the next carry or borrow, which with a small trim can be many ticks later. The bench therefore runs long tick sequences over a sweep of magnitudes, signs and lengths, and compares both the accumulator and the count against closed-form results. A wrong capture state shows on the first low or high read after the counter has moved, so the capture tests advance the counter between reads. A bad load or a bad wrap shows on the first readback after the write or the wrap edge.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   typedef enum logic [2:0] {
      RA_SUBNS = 3'd0,
      RA_LOW   = 3'd1,
      RA_HIGH  = 3'd2,
      RA_TRIM  = 3'd3,
      RA_CTRL  = 3'd4
   } reg_addr_e;

   localparam int HALT_BIT = 31;
endpackage

// File: rtl/ptp_tod_frac.sv
module ptp_tod_frac #(
   parameter int FRAC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              neg,
   input  logic [FRAC_W-2:0] mag,
   input  logic              clr,
   input  logic              ld,
   input  logic [FRAC_W-1:0] ld_val,
   output logic [FRAC_W-1:0] frac,
   output logic              adj
);
   logic [FRAC_W:0]   sum_w, dif_w;
   logic [FRAC_W-1:0] nxt;

   initial assert (FRAC_W >= 2) else $error("FRAC_W too small");

   always_comb begin
      sum_w = {1'b0, frac} + {2'b00, mag};
      dif_w = {1'b0, frac} - {2'b00, mag};
      adj   = neg ? dif_w[FRAC_W] : sum_w[FRAC_W];
      nxt   = neg ? dif_w[FRAC_W-1:0] : sum_w[FRAC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   frac <= '0;
      else if (clr) frac <= '0;
      else if (ld)  frac <= ld_val;
      else if (adv) frac <= nxt;
   end

   // R7: clearing on a time load leaves an empty accumulator
   a_r7_frac_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> frac == '0);
   // R8: a direct load lands in the accumulator
   a_r8_frac_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr) |=> frac == $past(ld_val));
endmodule

// File: rtl/ptp_tod_ns.sv
module ptp_tod_ns #(
   parameter int NS_W = 40,
   parameter int STEP = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            neg,
   input  logic            adj,
   input  logic            ld,
   input  logic [NS_W-1:0] ld_val,
   output logic [NS_W-1:0] ns
);
   localparam logic [NS_W-1:0] STEP_V = NS_W'(STEP);
   logic [NS_W-1:0] nxt;

   initial assert (STEP > 1) else $error("STEP must exceed one");

   always_comb begin
      nxt = ns + STEP_V;
      if (adj) nxt = neg ? nxt - NS_W'(1) : nxt + NS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ns <= '0;
      else if (ld)  ns <= ld_val;
      else if (adv) ns <= nxt;
   end

   // R1: a counted tick moves by the base step, trimmed by at most one
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld) |=> (NS_W'(ns - $past(ns)) == STEP_V)
                    || (NS_W'(ns - $past(ns)) == NS_W'(STEP + 1) && !$past(neg))
                    || (NS_W'(ns - $past(ns)) == NS_W'(STEP - 1) && $past(neg)));
   // R1: no tick, no load, no change
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld) |=> $stable(ns));
endmodule

// File: rtl/ptp_tod_snap.sv
module ptp_tod_snap #(
   parameter int NS_W = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_sub,
   input  logic            rd_low,
   input  logic            rd_high,
   input  logic [NS_W-1:0] ns_live,
   output logic            held,
   output logic [NS_W-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         snap <= '0;
      end else if (rd_sub || (rd_low && !held)) begin
         held <= 1'b1;
         snap <= ns_live;
      end else if (rd_high) begin
         held <= 1'b0;
      end
   end

   // R5: a held capture is frozen until a new sub-ns read
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !rd_sub) |=> $stable(snap));
   // R6: a high read releases the capture
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_high && !rd_sub && !rd_low) |=> !held);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int NS_W   = 40,
   parameter int STEP   = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata
);
   localparam int FRAC_W  = REG_W;
   localparam int HI_BITS = NS_W - REG_W;

   initial assert (NS_W > REG_W && NS_W <= 2*REG_W)
      else $error("NS_W must span the low word and part of the high word");
   initial assert (ADDR_W >= 3) else $error("ADDR_W too small");
   initial assert (REG_W > HALT_BIT) else $error("REG_W too small for control");

   logic              halt_q;
   logic [REG_W-1:0]  trim_q, stage_lo, rdata_q;
   logic [FRAC_W-1:0] frac;
   logic [NS_W-1:0]   ns, snap;
   logic              held, adj, adv, neg;
   logic              wr_sub, wr_low, wr_high, wr_trim, wr_ctrl;
   logic              rd_sub, rd_low, rd_high;
   logic [NS_W-1:0]   ns_view;
   logic [REG_W-1:0]  hi_word, rd_mux;

   always_comb begin
      wr_sub  = wr_en && addr == ADDR_W'(RA_SUBNS);
      wr_low  = wr_en && addr == ADDR_W'(RA_LOW);
      wr_high = wr_en && addr == ADDR_W'(RA_HIGH);
      wr_trim = wr_en && addr == ADDR_W'(RA_TRIM);
      wr_ctrl = wr_en && addr == ADDR_W'(RA_CTRL);
      rd_sub  = rd_en && addr == ADDR_W'(RA_SUBNS);
      rd_low  = rd_en && addr == ADDR_W'(RA_LOW);
      rd_high = rd_en && addr == ADDR_W'(RA_HIGH);
      adv     = tick && !halt_q;
      neg     = trim_q[REG_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q   <= 1'b1;
         trim_q   <= '0;
         stage_lo <= '0;
      end else begin
         if (wr_ctrl) halt_q   <= wdata[HALT_BIT];
         if (wr_trim) trim_q   <= wdata;
         if (wr_low)  stage_lo <= wdata;
      end
   end

   ptp_tod_frac #(.FRAC_W(FRAC_W)) u_frac (
      .clk(clk), .rst_n(rst_n), .adv(adv), .neg(neg),
      .mag(trim_q[FRAC_W-2:0]), .clr(wr_high), .ld(wr_sub),
      .ld_val(wdata), .frac(frac), .adj(adj)
   );

   ptp_tod_ns #(.NS_W(NS_W), .STEP(STEP)) u_ns (
      .clk(clk), .rst_n(rst_n), .adv(adv), .neg(neg), .adj(adj),
      .ld(wr_high), .ld_val({wdata[HI_BITS-1:0], stage_lo}), .ns(ns)
   );

   ptp_tod_snap #(.NS_W(NS_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd_sub(rd_sub), .rd_low(rd_low),
      .rd_high(rd_high), .ns_live(ns), .held(held), .snap(snap)
   );

   assign ns_view = held ? snap : ns;

   generate
      if (HI_BITS < REG_W) begin : g_pad
         assign hi_word = {{(REG_W-HI_BITS){1'b0}}, ns_view[NS_W-1:REG_W]};
      end else begin : g_full
         assign hi_word = ns_view[NS_W-1:REG_W];
      end
   endgenerate

   always_comb begin
      case (addr)
         ADDR_W'(RA_SUBNS): rd_mux = frac;
         ADDR_W'(RA_LOW):   rd_mux = ns_view[REG_W-1:0];
         ADDR_W'(RA_HIGH):  rd_mux = hi_word;
         ADDR_W'(RA_TRIM):  rd_mux = trim_q;
         ADDR_W'(RA_CTRL):  rd_mux = REG_W'(halt_q) << HALT_BIT;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_en)  rdata_q <= rd_mux;
   end
   assign rdata = rdata_q;

   // R4: reserved high-word bits never read as one
   a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      rd_high |=> rdata[REG_W-1:HI_BITS] == '0);
   // R7: a high write loads both halves at once
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_high |=> ns == {$past(wdata[HI_BITS-1:0]), $past(stage_lo)});
   // R9: a halted counter holds unless loaded
   a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_high) |=> $stable(ns));
   // R11: read data holds between reads
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
   localparam int CLK_NS = 10;
   localparam longint unsigned M32 = 64'hFFFF_FFFF;
   localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;

   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   int          errors = 0, checks = 0;

   ptp_tod_counter uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(input longint unsigned t);
      wr(3'd1, t[31:0]);
      wr(3'd2, {24'h0, t[39:32]});
   endtask

   task automatic read_all(output longint unsigned fr, output longint unsigned t);
      logic [31:0] s, l, h;
      rd(3'd0, s); rd(3'd1, l); rd(3'd2, h);
      fr = s; t = {h, l};
   endtask

   initial begin
      #(CLK_NS * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      longint unsigned fr, t, prod, expn, expf;
      longint unsigned mags[5] = '{0, 1, 64'h7FFF_FFFF, 64'h4000_0000, 64'h1234_5678};
      int lens[4] = '{1, 3, 17, 100};

      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 rdata", rdata, 0);
      rst_n = 1'b1;
      rd(3'd4, v); check("R9 reset halt", v, 32'h8000_0000);
      rd(3'd3, v); check("R10 trim", v, 0);
      ticks(10);
      read_all(fr, t);
      check("R9 halted frac", fr, 0);
      check("R9 halted count", t, 0);
      wr(3'd4, 32'h0);
      rd(3'd4, v); check("R9 enabled", v, 0);

      // R2 R3: sweep magnitude, sign and length
      foreach (mags[i]) foreach (lens[j]) for (int s = 0; s < 2; s++) begin
         longint unsigned base = 64'h12_3456_7000;
         set_time(base);
         wr(3'd3, {s[0], mags[i][30:0]});
         ticks(lens[j]);
         read_all(fr, t);
         prod = mags[i] * longint'(lens[j]);
         if (s == 0) begin
            expn = (base + 8*lens[j] + (prod >> 32)) & M40;
            expf = prod & M32;
         end else begin
            expn = (base + 8*lens[j] - ((prod + M32) >> 32)) & M40;
            expf = (64'h1_0000_0000 - (prod & M32)) & M32;
         end
         check(s == 0 ? "R2 count" : "R3 count", t, expn);
         check(s == 0 ? "R2 frac"  : "R3 frac",  fr, expf);
      end

      // R4: wrap and reserved bits
      wr(3'd3, 32'h0);
      wr(3'd1, 32'hFFFF_FFF8);
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); check("R4 reserved", v, 32'h0000_00FF);
      ticks(1);
      read_all(fr, t); check("R4 wrap", t, 0);

      // R5 R6 R1: capture survives ticks, released by high read
      set_time(64'hAB_0000_1000);
      rd(3'd0, v);
      ticks(5);
      rd(3'd1, v); check("R5 low frozen", v, 32'h0000_1000);
      rd(3'd2, v); check("R5 high frozen", v, 32'h0000_00AB);
      rd(3'd1, v); check("R6 live low", v, 32'h0000_1028);
      repeat (4) @(negedge clk);
      check("R11 hold", rdata, 32'h0000_1028);
      ticks(2);
      rd(3'd2, v); check("R6 low-capture high", v, 32'h0000_00AB);
      rd(3'd1, v); check("R1 idle edges", v, 32'h0000_1038);
      rd(3'd2, v);

      // R7 R8: staged low, load clears accumulator, direct accumulator load
      wr(3'd3, 32'h0000_0001);
      ticks(3);
      wr(3'd1, 32'h0000_0500);
      read_all(fr, t); check("R7 low staged only", t, 64'hAB_0000_1038 + 24);
      wr(3'd2, 32'h0000_0001);
      read_all(fr, t);
      check("R7 loaded", t, 64'h01_0000_0500);
      check("R7 frac cleared", fr, 0);
      wr(3'd0, 32'hFFFF_FFFF);
      ticks(1);
      read_all(fr, t);
      check("R8 carry count", t, 64'h01_0000_0509);
      check("R8 carry frac", fr, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule